// File: doc/BRIEF.md
# Real-Time Clock Time and Calendar Update Engine

This block keeps the time of day and a 100-year calendar. A prescaler counts enables from a 32.768 kHz time base. When it reaches the end of each second, it runs an update. The update advances a private working copy of the time. It can also refresh a host-visible buffer of ten bytes: the time and calendar fields plus three alarm fields. A warning flag goes high a fixed number of time-base ticks before every update. A sticky completion flag is raised when the update finishes. A sticky alarm flag is raised when the updated seconds, minutes and hours equal the three alarm bytes.

The host programs the block through a byte write port. Setting the transfer-inhibit input freezes the host buffer while the working copy keeps counting. Two control inputs choose the encoding of every byte at run time: binary or BCD, and 24-hour or 12-hour with a PM bit. The working copy is always held in plain binary. Each transfer rebuilds all ten buffer bytes in the encoding selected at that moment. A write is decoded using the encoding selected at the time of the write.

Top module: `rtc_update_engine`

## Requirements
- R1: After reset all flags are 0, the working copy holds 00:00:00 on weekday 1, day 1, month 1, year 0, the alarm is 00:00:00, and buffer bytes 0..9 read 00,00,00,00,00,00,01,01,01,00 (hex).
- R2: `uip` rises on the time-base enable that leaves the prescaler `LEAD_TICKS+UPD_TICKS` enables before the end of the second. It falls on the enable that ends the second, and `uf` becomes 1 in that same clock cycle.
- R3: Every `TICKS_PER_SEC` time-base enables the working copy advances by one second. Seconds and minutes count 0..59 and carry into the next field. Hours count 0..23 and carry into the date.
- R4: When the day rolls over, the weekday goes 7 to 1. The day of month wraps to 1 after 28 or 29 days in February (29 when year mod 4 is 0), after 30 days in April, June, September and November, and after 31 days in the other months. The month goes 12 to 1, and the year goes 99 to 0.
- R5: While `inhibit` is 1, updates do not change the buffer, but the working copy keeps advancing. The first update after `inhibit` returns to 0 shows the advanced time.
- R6: With `fmt_bin`=1 the bytes are plain binary; with `fmt_bin`=0 they are BCD (tens in bits 7:4, units in bits 3:0). Changing the format leaves the buffer untouched until the next transfer, which re-encodes all ten bytes including the alarm bytes.
- R7: With `mode_24h`=0 the hour bytes 4 and 5 hold 1..12 with bit 7 = PM. Midnight reads 12 AM (BCD 0x12) and noon reads 12 PM (BCD 0x92, binary 0x8C).
- R8: A write with `wr_addr` 0..9 stores `wr_data` unchanged into that buffer byte on the next cycle, and loads the decoded value into the working copy. Byte order: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year. Writes to 10..15 change nothing.
- R9: `af` is set by an update whose new seconds, minutes and hours equal the alarm bytes. It stays 1 until cleared.
- R10: `flag_clr` clears `uf` and `af` on the next cycle. A flag being set in that same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz time-base period |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 4 | Host byte address |
| wr_data | input | 8 | Host write data |
| inhibit | input | 1 | 1 = freeze the host buffer during updates |
| fmt_bin | input | 1 | 1 = binary, 0 = BCD encoding |
| mode_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| flag_clr | input | 1 | Clear the completion and alarm flags |
| buf_bytes | output | 80 | Host buffer, byte i at bits 8*i+7:8*i |
| uip | output | 1 | Update-in-progress warning |
| uf | output | 1 | Sticky update-complete flag |
| af | output | 1 | Sticky alarm-match flag |

## Verification
The bench builds the block with `TICKS_PER_SEC`=16, `LEAD_TICKS`=4 and `UPD_TICKS`=3, and gates the time-base enable randomly. With these values a second lasts about twenty clock cycles, the warning window spans seven enables, and many seconds of runtime cost only a few thousand cycles. Midnight, month-end, leap-February and year-99 rollovers are reached by presetting the time just before them. With the prescaler this short, random times in every encoding combination can be checked second by second against the bench's own calendar model.

// File: rtl/rtc_pkg.sv
// Shared types and conversion helpers for the clock/calendar update engine.
// Assumes the working copy is always plain binary with hours kept 0..23.
package rtc_pkg;

    localparam int NBYTES = 10;

    localparam logic [3:0] A_SEC   = 4'd0;
    localparam logic [3:0] A_ASEC  = 4'd1;
    localparam logic [3:0] A_MIN   = 4'd2;
    localparam logic [3:0] A_AMIN  = 4'd3;
    localparam logic [3:0] A_HOUR  = 4'd4;
    localparam logic [3:0] A_AHOUR = 4'd5;
    localparam logic [3:0] A_DOW   = 4'd6;
    localparam logic [3:0] A_DOM   = 4'd7;
    localparam logic [3:0] A_MON   = 4'd8;
    localparam logic [3:0] A_YEAR  = 4'd9;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] year;
        logic [6:0] asec;
        logic [6:0] amin;
        logic [4:0] ahour;
    } rtc_time_t;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens, ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        logic [7:0] s;
        s = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
        return s[6:0];
    endfunction

    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : from_bcd(b);
    endfunction

    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin, input logic h24);
        logic [6:0] h12;
        logic [7:0] e;
        if (h24) return enc_val({2'b00, h}, bin);
        if (h == 5'd0)       h12 = 7'd12;
        else if (h > 5'd12)  h12 = {2'b00, h} - 7'd12;
        else                 h12 = {2'b00, h};
        e = enc_val(h12, bin);
        return {(h >= 5'd12), e[6:0]};
    endfunction

    function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
        logic [6:0] v;
        if (h24) begin
            v = dec_val(b, bin);
            return v[4:0];
        end
        v = dec_val({1'b0, b[6:0]}, bin);
        if (v == 7'd12) v = 7'd0;
        if (b[7])       v = v + 7'd12;
        return v[4:0];
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] year);
        case (mon)
            4'd2:                      return (year[1:0] == 2'd0) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    function automatic rtc_time_t advance(input rtc_time_t t);
        rtc_time_t r;
        r = t;
        if (t.sec < 7'd59) r.sec = t.sec + 7'd1;
        else begin
            r.sec = 7'd0;
            if (t.min < 7'd59) r.min = t.min + 7'd1;
            else begin
                r.min = 7'd0;
                if (t.hour < 5'd23) r.hour = t.hour + 5'd1;
                else begin
                    r.hour = 5'd0;
                    r.dow  = (t.dow >= 3'd7) ? 3'd1 : t.dow + 3'd1;
                    if (t.dom < month_len(t.mon, t.year)) r.dom = t.dom + 5'd1;
                    else begin
                        r.dom = 5'd1;
                        if (t.mon < 4'd12) r.mon = t.mon + 4'd1;
                        else begin
                            r.mon  = 4'd1;
                            r.year = (t.year >= 7'd99) ? 7'd0 : t.year + 7'd1;
                        end
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] enc_byte(input rtc_time_t t, input logic [3:0] idx,
                                            input logic bin, input logic h24);
        case (idx)
            A_SEC:   return enc_val(t.sec, bin);
            A_ASEC:  return enc_val(t.asec, bin);
            A_MIN:   return enc_val(t.min, bin);
            A_AMIN:  return enc_val(t.amin, bin);
            A_HOUR:  return enc_hour(t.hour, bin, h24);
            A_AHOUR: return enc_hour(t.ahour, bin, h24);
            A_DOW:   return enc_val({4'd0, t.dow}, bin);
            A_DOM:   return enc_val({2'd0, t.dom}, bin);
            A_MON:   return enc_val({3'd0, t.mon}, bin);
            A_YEAR:  return enc_val(t.year, bin);
            default: return 8'h00;
        endcase
    endfunction

    function automatic rtc_time_t apply_write(input rtc_time_t t, input logic [3:0] idx,
                                              input logic [7:0] d, input logic bin, input logic h24);
        rtc_time_t r;
        logic [6:0] v;
        r = t;
        v = dec_val(d, bin);
        case (idx)
            A_SEC:   r.sec   = v;
            A_ASEC:  r.asec  = v;
            A_MIN:   r.min   = v;
            A_AMIN:  r.amin  = v;
            A_HOUR:  r.hour  = dec_hour(d, bin, h24);
            A_AHOUR: r.ahour = dec_hour(d, bin, h24);
            A_DOW:   r.dow   = v[2:0];
            A_DOM:   r.dom   = v[4:0];
            A_MON:   r.mon   = v[3:0];
            A_YEAR:  r.year  = v;
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Counts time-base enables into seconds. It raises the update warning a fixed
// lead before the end of each second and pulses end_pulse on the enable that
// closes the second. Assumes LEAD_TICKS+UPD_TICKS < TICKS_PER_SEC.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 80,
    parameter int UPD_TICKS     = 66
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic end_pulse,
    output logic uip
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] WARN = CW'(TICKS_PER_SEC - LEAD_TICKS - UPD_TICKS - 1);

    logic [CW-1:0] cnt;

    // Last enable of the second closes the update cycle.
    assign end_pulse = tick_en && (cnt == LAST);

    // Prescaler count, wrapping once per second.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (end_pulse) cnt <= '0;
        else if (tick_en)   cnt <= cnt + 1'b1;
    end

    // Warning flag: set at the lead point, cleared when the update ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                        uip <= 1'b0;
        else if (end_pulse)                uip <= 1'b0;
        else if (tick_en && cnt == WARN)   uip <= 1'b1;
    end

    AST_UIP_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> uip); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R3

endmodule

// File: rtl/rtc_time_core.sv
// Working copy of time, calendar and alarm in plain binary. At each end of
// second it advances the time; a host write overrides one field. It also
// produces the next-state record and the alarm-match strobe.
module rtc_time_core import rtc_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       end_pulse,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       fmt_bin,
    input  logic       mode_24h,
    output rtc_time_t  nxt,
    output logic       alarm_hit
);
    rtc_time_t cur;
    rtc_time_t rst_val;

    // Power-on contents of the working copy.
    always_comb begin
        rst_val = '0;
        rst_val.dow = 3'd1;
        rst_val.dom = 5'd1;
        rst_val.mon = 4'd1;
    end

    // Next state: advance on end of second, then apply any host write.
    always_comb begin
        nxt = cur;
        if (end_pulse) nxt = advance(cur);
        if (wr_en && wr_addr < 4'(NBYTES))
            nxt = apply_write(nxt, wr_addr, wr_data, fmt_bin, mode_24h);
        alarm_hit = end_pulse && (nxt.sec == nxt.asec) &&
                    (nxt.min == nxt.amin) && (nxt.hour == nxt.ahour);
    end

    // Working-copy register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= rst_val;
        else        cur <= nxt;
    end

    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_pulse && !wr_en) |=> $stable(cur)); // R3
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse && !wr_en && cur.sec < 7'd59) |=> (cur.sec == $past(cur.sec) + 7'd1)); // R3

endmodule

// File: rtl/rtc_host_buffer.sv
// Host-visible byte buffer. A write stores raw data into its byte. An
// uninhibited end of second re-encodes all ten bytes from the next-state record
// in the current format. Assumes a write wins over a transfer for its own byte.
module rtc_host_buffer import rtc_pkg::*; (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  end_pulse,
    input  logic                  inhibit,
    input  rtc_time_t             nxt,
    input  logic                  wr_en,
    input  logic [3:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  fmt_bin,
    input  logic                  mode_24h,
    output logic [8*NBYTES-1:0]   buf_bytes
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam logic [3:0] IDX = 4'(i);
        localparam logic [7:0] RST = (i == 6 || i == 7 || i == 8) ? 8'h01 : 8'h00;

        // One buffer byte: write first, else transfer, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                buf_bytes[8*i +: 8] <= RST;
            else if (wr_en && wr_addr == IDX)
                buf_bytes[8*i +: 8] <= wr_data;
            else if (end_pulse && !inhibit)
                buf_bytes[8*i +: 8] <= enc_byte(nxt, IDX, fmt_bin, mode_24h);
        end
    end

    AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !wr_en) |=> $stable(buf_bytes)); // R5

endmodule

// File: rtl/rtc_update_engine.sv
// Top of the clock/calendar update engine: prescaler, working copy, host
// buffer and the sticky completion and alarm flags. Assumes tick_en is a
// one-cycle enable per time-base period and all inputs are synchronous to clk.
module rtc_update_engine import rtc_pkg::*; #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 80,
    parameter int UPD_TICKS     = 66
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        inhibit,
    input  logic        fmt_bin,
    input  logic        mode_24h,
    input  logic        flag_clr,
    output logic [79:0] buf_bytes,
    output logic        uip,
    output logic        uf,
    output logic        af
);
    logic      end_pulse;
    logic      alarm_hit;
    rtc_time_t nxt;

    rtc_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .LEAD_TICKS   (LEAD_TICKS),
        .UPD_TICKS    (UPD_TICKS)
    ) i_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .end_pulse(end_pulse), .uip(uip)
    );

    rtc_time_core i_core (
        .clk(clk), .rst_n(rst_n), .end_pulse(end_pulse),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fmt_bin(fmt_bin), .mode_24h(mode_24h),
        .nxt(nxt), .alarm_hit(alarm_hit)
    );

    rtc_host_buffer i_buf (
        .clk(clk), .rst_n(rst_n), .end_pulse(end_pulse), .inhibit(inhibit),
        .nxt(nxt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fmt_bin(fmt_bin), .mode_24h(mode_24h), .buf_bytes(buf_bytes)
    );

    // Completion flag: set at end of each update, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         uf <= 1'b0;
        else if (end_pulse) uf <= 1'b1;
        else if (flag_clr)  uf <= 1'b0;
    end

    // Alarm flag: set on match during an update, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         af <= 1'b0;
        else if (alarm_hit) af <= 1'b1;
        else if (flag_clr)  af <= 1'b0;
    end

    AST_UF_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> (uf && !uip)); // R2
    AST_AF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (af && !flag_clr) |=> af); // R9
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !end_pulse) |=> !uf); // R10

endmodule

// File: tb/test_rtc_update_engine.sv
`timescale 1ns/1ps
module test_rtc_update_engine;
    localparam int TPS = 16, LEAD = 4, UPD = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, inhibit = 1'b0;
    logic fmt_bin = 1'b1, mode_24h = 1'b1, flag_clr = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [79:0] buf_bytes;
    logic uip, uf, af;

    rtc_update_engine #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) i_rtc_update_engine (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .inhibit(inhibit), .fmt_bin(fmt_bin), .mode_24h(mode_24h),
        .flag_clr(flag_clr), .buf_bytes(buf_bytes), .uip(uip), .uf(uf), .af(af));

    int total = 0, bad = 0, m_ends = 0, seen_ends = 0, mcnt = 0;
    bit done = 0, tick_on = 0, muip = 0, muf = 0, maf = 0;
    int ms, mm, mh, mdw, mdm, mmo, my, mas, mam, mah;
    logic [7:0] mbuf [10];

    // ---- bench encoding functions ----
    function automatic logic [7:0] f_enc(int v, bit bin);
        return bin ? 8'(v) : 8'((v / 10) * 16 + v % 10);
    endfunction
    function automatic int f_dec(logic [7:0] b, bit bin);
        return bin ? int'(b[6:0]) : int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] f_ench(int h, bit bin, bit h24);
        int h12;
        if (h24) return f_enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return f_enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction
    function automatic int f_dech(logic [7:0] b, bit bin, bit h24);
        if (h24) return f_dec(b, bin);
        return (f_dec({1'b0, b[6:0]}, bin) % 12) + (b[7] ? 12 : 0);
    endfunction
    function automatic int f_mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic logic [7:0] f_get(int i);
        case (i)
            0: return f_enc(ms, fmt_bin);
            1: return f_enc(mas, fmt_bin);
            2: return f_enc(mm, fmt_bin);
            3: return f_enc(mam, fmt_bin);
            4: return f_ench(mh, fmt_bin, mode_24h);
            5: return f_ench(mah, fmt_bin, mode_24h);
            6: return f_enc(mdw, fmt_bin);
            7: return f_enc(mdm, fmt_bin);
            8: return f_enc(mmo, fmt_bin);
            default: return f_enc(my, fmt_bin);
        endcase
    endfunction
    function automatic logic [7:0] bb(int i);
        return buf_bytes[8*i +: 8];
    endfunction

    task automatic m_adv();
        if (ms < 59) ms++;
        else begin
            ms = 0;
            if (mm < 59) mm++;
            else begin
                mm = 0;
                if (mh < 23) mh++;
                else begin
                    mh = 0;
                    mdw = (mdw == 7) ? 1 : mdw + 1;
                    if (mdm < f_mdays(mmo, my)) mdm++;
                    else begin
                        mdm = 1;
                        if (mmo < 12) mmo++;
                        else begin mmo = 1; my = (my == 99) ? 0 : my + 1; end
                    end
                end
            end
        end
    endtask

    task automatic m_wr(int a, logic [7:0] d);
        case (a)
            0: ms  = f_dec(d, fmt_bin);
            1: mas = f_dec(d, fmt_bin);
            2: mm  = f_dec(d, fmt_bin);
            3: mam = f_dec(d, fmt_bin);
            4: mh  = f_dech(d, fmt_bin, mode_24h);
            5: mah = f_dech(d, fmt_bin, mode_24h);
            6: mdw = f_dec(d, fmt_bin);
            7: mdm = f_dec(d, fmt_bin);
            8: mmo = f_dec(d, fmt_bin);
            9: my  = f_dec(d, fmt_bin);
            default: ;
        endcase
    endtask

    // Reference model of the requirements, stepped on each clock edge.
    always @(posedge clk) begin : model
        bit e, hit;
        int oc;
        if (!rst_n) begin
            mcnt = 0; muip = 0; muf = 0; maf = 0;
            ms = 0; mm = 0; mh = 0; mdw = 1; mdm = 1; mmo = 1; my = 0;
            mas = 0; mam = 0; mah = 0;
            for (int i = 0; i < 10; i++) mbuf[i] = (i >= 6 && i <= 8) ? 8'h01 : 8'h00;
        end else begin
            oc = mcnt;
            e = tick_en && (mcnt == TPS - 1);
            if (tick_en) mcnt = (mcnt == TPS - 1) ? 0 : mcnt + 1;
            if (e) muip = 0;
            else if (tick_en && oc == TPS - LEAD - UPD - 1) muip = 1;
            if (e) m_adv();
            if (wr_en && wr_addr < 10) m_wr(int'(wr_addr), wr_data);
            hit = e && ms == mas && mm == mam && mh == mah;
            if (e) muf = 1; else if (flag_clr) muf = 0;
            if (hit) maf = 1; else if (flag_clr) maf = 0;
            if (e && !inhibit) for (int i = 0; i < 10; i++) mbuf[i] = f_get(i);
            if (wr_en && wr_addr < 10) mbuf[wr_addr] = wr_data;
            if (e) m_ends++;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle warning flag check and per-second full comparison.
    initial forever begin
        @(negedge clk);
        if (rst_n && !done) begin
            chk("R2 uip", {7'd0, uip}, {7'd0, muip});
            if (m_ends != seen_ends) begin
                seen_ends = m_ends;
                for (int i = 0; i < 10; i++)
                    chk(inhibit ? "R5 frozen byte" : "R3 updated byte", bb(i), mbuf[i]);
                chk("R2 uf", {7'd0, uf}, {7'd0, muf});
                chk("R9 af", {7'd0, af}, {7'd0, maf});
            end
        end
    end

    // Time-base enable, randomly gated.
    initial forever begin
        @(negedge clk);
        tick_en = tick_on && ($urandom % 4 != 0);
    end

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ends(int n);
        int t = m_ends + n;
        while (m_ends < t) @(negedge clk);
    endtask

    task automatic set_time(int s, int m, int h, int dw, int dm, int mo, int y);
        tick_on = 0; inhibit = 1'b1;
        @(negedge clk);
        wr(0, f_enc(s, fmt_bin)); wr(2, f_enc(m, fmt_bin));
        wr(4, f_ench(h, fmt_bin, mode_24h)); wr(6, f_enc(dw, fmt_bin));
        wr(7, f_enc(dm, fmt_bin)); wr(8, f_enc(mo, fmt_bin)); wr(9, f_enc(y, fmt_bin));
    endtask

    task automatic run(int n);
        inhibit = 1'b0; tick_on = 1;
        wait_ends(n);
        tick_on = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_flags();
        tick_on = 0;
        repeat (2) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1; bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b0;
        void'($urandom(32'h1D2C3B4A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 10; i++) chk("R1 reset byte", bb(i), (i >= 6 && i <= 8) ? 8'h01 : 8'h00);
        chk("R1 flags", {5'd0, uip, uf, af}, 8'h00);

        // R8 write and ignored high addresses; R4 non-leap February, R9 midnight alarm
        set_time(58, 59, 23, 7, 28, 2, 3);
        chk("R8 raw write", bb(0), 8'h3A);
        wr(12, 8'h55);
        chk("R8 addr 12 ignored", bb(0), 8'h3A);
        chk("R8 addr 12 ignored", bb(9), 8'h03);
        run(2);
        chk("R4 hour wrap", bb(4), 8'h00);
        chk("R4 weekday 7->1", bb(6), 8'h01);
        chk("R4 Feb 28 non-leap", bb(7), 8'h01);
        chk("R4 month", bb(8), 8'h03);
        chk("R9 midnight alarm", {7'd0, af}, 8'h01);
        clear_flags();
        chk("R10 clear", {6'd0, uf, af}, 8'h00);

        // R4 leap year
        set_time(59, 59, 23, 3, 28, 2, 4);
        run(1);
        chk("R4 leap Feb 29", bb(7), 8'd29);
        set_time(59, 59, 23, 3, 29, 2, 4);
        run(1);
        chk("R4 leap end day", bb(7), 8'd1);
        chk("R4 leap end month", bb(8), 8'd3);
        // R4 century wrap
        set_time(59, 59, 23, 5, 31, 12, 99);
        run(1);
        chk("R4 year 99->0", bb(9), 8'd0);
        chk("R4 Dec->Jan", bb(8), 8'd1);

        // R7 12-hour BCD: noon and midnight
        fmt_bin = 1'b0; mode_24h = 1'b0;
        set_time(59, 59, 11, 2, 10, 5, 20);
        wr(1, 8'h45);
        run(1);
        chk("R7 noon BCD", bb(4), 8'h92);
        set_time(59, 59, 23, 2, 10, 5, 20);
        run(1);
        chk("R7 midnight BCD", bb(4), 8'h12);

        // R6 format switch takes effect at next transfer
        b0 = bb(1);
        fmt_bin = 1'b1; mode_24h = 1'b1;
        @(negedge clk);
        chk("R6 no change before transfer", bb(1), b0);
        run(1);
        chk("R6 alarm byte re-encoded", bb(1), 8'h2D);
        chk("R6 hour binary", bb(4), 8'h00);
        mode_24h = 1'b0;
        set_time(59, 59, 11, 2, 10, 5, 20);
        run(1);
        chk("R7 noon binary", bb(4), 8'h8C);
        mode_24h = 1'b1;

        // R5 inhibit freezes buffer, internal keeps counting
        b0 = bb(0);
        inhibit = 1'b1; tick_on = 1;
        wait_ends(3);
        chk("R5 frozen seconds", bb(0), b0);
        inhibit = 1'b0;
        wait_ends(1);
        tick_on = 0;
        chk("R5 caught up", bb(0), 8'((f_dec(b0, 1) + 4) % 60));

        // R9 alarm two seconds ahead
        set_time(10, 20, 5, 1, 1, 1, 1);
        wr(1, 8'd12); wr(3, 8'd20); wr(5, 8'd5);
        clear_flags();
        run(1);
        chk("R9 no early alarm", {7'd0, af}, 8'h00);
        run(1);
        chk("R9 alarm match", {7'd0, af}, 8'h01);
        // R10 set wins over clear: pulse clear across the end of a second
        inhibit = 1'b0; tick_on = 1;
        flag_clr = 1'b1;
        wait_ends(1);
        flag_clr = 1'b0;
        tick_on = 0;
        chk("R10 set wins over clear", {7'd0, uf}, 8'h01);

        // Random times, formats and alarms checked every second against the model
        for (int k = 0; k < 25; k++) begin
            fmt_bin = 1'($urandom % 2); mode_24h = 1'($urandom % 2);
            begin
                int mo = 1 + $urandom % 12, y = $urandom % 100;
                set_time($urandom % 60, $urandom % 60, $urandom % 24, 1 + $urandom % 7,
                         1 + $urandom % f_mdays(mo, y), mo, y);
            end
            wr(1, f_enc($urandom % 60, fmt_bin));
            wr(5, f_ench($urandom % 24, fmt_bin, mode_24h));
            if (k % 5 == 0) begin
                set_time(58, 59, 23, 7, f_mdays(2, 0), 2, 0);
            end
            run(1 + $urandom % 4);
            clear_flags();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule